// File: doc/BRIEF.md
# Dual-Issue Warp Dispatch Unit

This block is the issue stage of one multiprocessor. A pool of warps, each of 32 threads, is split between two schedulers: scheduler 0 owns the even warp IDs and scheduler 1 owns the odd ones. Each warp presents a ready flag and a 3-bit instruction class. In every cycle each scheduler may pick one of its warps and send that warp's next instruction to one of four execution groups. The groups are core column A, core column B, the load/store group and the special-function group.

The groups stay busy for different lengths of time. A 16-lane group needs two cycles for a 32-thread instruction. The 4-lane special-function group needs eight cycles. While the special-function group is busy, both ports keep issuing to the other groups. A double-precision instruction takes both core columns and issues alone in its cycle. When both schedulers compete for a group, scheduler 0 is served first. Scheduler 1 then looks for another of its warps that it can still place.

The outputs are combinational from the current warp inputs and the registered group and pointer state. Per port they give a valid bit, the warp ID and the group grant.

Top module: `warp_dual_issue`

## Requirements
- R1: Port 0 issues only even warp IDs and port 1 only odd warp IDs. A port is valid only for a warp whose ready bit is set.
- R2: The grant bits are: bit 0 core column A, bit 1 core column B, bit 2 load/store, bit 3 special-function. The class codes are: 0 integer, 1 single float, 2 double float, 3 load/store, 4 special-function. An integer or single-float instruction goes to column A when A is free, otherwise to column B.
- R3: The two ports never hold a common grant bit in the same cycle.
- R4: A double-float instruction is granted 4'b0011 only when both columns are free. The other port issues nothing in that cycle.
- R5: Column A, column B and load/store are not granted in the cycle after a grant. They can be granted again in the cycle after that.
- R6: After a special-function grant, that group is not granted in the next 7 cycles and is free in the 8th. Meanwhile both ports keep issuing to the other groups.
- R7: Each scheduler issues the first issuable ready warp of its own that follows, in cyclic order, the warp it last issued. A warp is issuable when its group(s) are free. After reset the search begins at the lowest warp of each scheduler.
- R8: Port 0 is served first. If port 0 takes the group that a port 1 warp needs, port 1 issues another issuable warp of its own, or nothing.
- R9: Warps with class codes 5, 6 or 7 are never issued.
- R10: A synchronous active-high reset frees every group and sets both round-robin starts to the lowest warp. No port is valid while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_rdy | input | NUM_WARPS | Ready flag per warp |
| warp_cls | input | 3*NUM_WARPS | Instruction class per warp, warp w at bits [3w+2:3w] |
| iss_vld | output | 2 | Issue valid, bit p for port p |
| iss_wid0 | output | WID_W | Warp ID issued on port 0 |
| iss_wid1 | output | WID_W | Warp ID issued on port 1 |
| iss_grant0 | output | 4 | Group grant of port 0 |
| iss_grant1 | output | 4 | Group grant of port 1 |

## Verification
Two things can happen in the same cycle. One port can issue to a 16-lane group while the special-function group is still counting down. Both ports can also contend for the same free group, where port 0 wins and port 1 falls back. Directed sequences set these cases up from reset: a special-function grant followed by core and load/store warps, and two load/store warps on both ports with an integer warp left for port 1. They are judged against hand-worked cycle values. A long pseudo-random sweep of ready flags and classes is then compared every cycle with a bench model. The model tracks free times as absolute cycle numbers and scans round-robin by modulo arithmetic.

// File: rtl/warp_dual_issue_pkg.sv
package warp_dual_issue_pkg;
  localparam int NGRP = 4;
  localparam int GRP_A = 0;
  localparam int GRP_B = 1;
  localparam int GRP_MEM = 2;
  localparam int GRP_SFU = 3;

  localparam logic [2:0] CLS_INT = 3'd0;
  localparam logic [2:0] CLS_SPF = 3'd1;
  localparam logic [2:0] CLS_DPF = 3'd2;
  localparam logic [2:0] CLS_MEM = 3'd3;
  localparam logic [2:0] CLS_SFU = 3'd4;

  localparam logic [NGRP-1:0] DP_MASK = 4'b0011;

  // Group(s) a class would take given the free set; zero when it cannot issue.
  function automatic logic [NGRP-1:0] grant_for(input logic [2:0] cls,
                                                  input logic [NGRP-1:0] avail,
                                                  input logic dp_ok);
    logic [NGRP-1:0] g;
    g = '0;
    case (cls)
      CLS_INT, CLS_SPF: begin
        if (avail[GRP_A]) g[GRP_A] = 1'b1;
        else if (avail[GRP_B]) g[GRP_B] = 1'b1;
      end
      CLS_DPF: if (dp_ok && avail[GRP_A] && avail[GRP_B]) g = DP_MASK;
      CLS_MEM: if (avail[GRP_MEM]) g[GRP_MEM] = 1'b1;
      CLS_SFU: if (avail[GRP_SFU]) g[GRP_SFU] = 1'b1;
      default: g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/wdi_rr_pick.sv
module wdi_rr_pick #(
  parameter int N = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx = start;
    // scan from the farthest offset down so the nearest request wins last
    for (int k = N - 1; k >= 0; k--) begin
      logic [IW:0] pos;
      pos = {1'b0, start} + (IW+1)'(k);
      if (int'(pos) >= N) pos = pos - (IW+1)'(N);
      if (req[pos[IW-1:0]]) begin
        found = 1'b1;
        idx = pos[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/wdi_sched_slot.sv
module wdi_sched_slot
  import warp_dual_issue_pkg::*;
#(
  parameter int NL = 4,
  parameter int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic [NL-1:0]   rdy_loc,
  input  logic [3*NL-1:0] cls_loc,
  input  logic [NGRP-1:0] avail,
  input  logic            dp_ok,
  input  logic [LW-1:0]   start,
  output logic            found,
  output logic [LW-1:0]   idx,
  output logic [NGRP-1:0] gnt
);
  logic [NL-1:0] issuable;

  for (genvar j = 0; j < NL; j++) begin : g_req
    assign issuable[j] = rdy_loc[j] && (|grant_for(cls_loc[3*j +: 3], avail, dp_ok));
  end

  wdi_rr_pick #(.N(NL), .IW(LW)) u_pick (
    .req   (issuable),
    .start (start),
    .found (found),
    .idx   (idx)
  );

  assign gnt = found ? grant_for(cls_loc[3*idx +: 3], avail, dp_ok) : '0;
endmodule

// File: rtl/wdi_group_track.sv
module wdi_group_track
  import warp_dual_issue_pkg::*;
#(
  parameter int CORE_HOLD = 2,
  parameter int SFU_HOLD = 8,
  parameter int CW = $clog2(SFU_HOLD + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NGRP-1:0] take,
  output logic [NGRP-1:0] grp_free
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int HOLD = (g == GRP_SFU) ? SFU_HOLD : CORE_HOLD;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
      if (rst) left_q <= '0;
      else if (take[g]) left_q <= CW'(HOLD - 1);
      else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign grp_free[g] = (left_q == '0);
  end
endmodule

// File: rtl/warp_dual_issue.sv
module warp_dual_issue
  import warp_dual_issue_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int CORE_HOLD = 2,
  parameter int SFU_HOLD = 8,
  parameter int WID_W = $clog2(NUM_WARPS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_WARPS-1:0]   warp_rdy,
  input  logic [3*NUM_WARPS-1:0] warp_cls,
  output logic [1:0]             iss_vld,
  output logic [WID_W-1:0]       iss_wid0,
  output logic [WID_W-1:0]       iss_wid1,
  output logic [NGRP-1:0]        iss_grant0,
  output logic [NGRP-1:0]        iss_grant1
);
  localparam int NL = NUM_WARPS / 2;
  localparam int LW = WID_W - 1;

  logic [NL-1:0]   rdy_even, rdy_odd;
  logic [3*NL-1:0] cls_even, cls_odd;

  for (genvar j = 0; j < NL; j++) begin : g_split
    assign rdy_even[j] = warp_rdy[2*j];
    assign rdy_odd[j]  = warp_rdy[2*j+1];
    assign cls_even[3*j +: 3] = warp_cls[6*j +: 3];
    assign cls_odd[3*j +: 3]  = warp_cls[6*j+3 +: 3];
  end

  // named internal events used by the checker
  logic [NGRP-1:0] grp_free;
  logic [NGRP-1:0] grp_take;
  logic            p0_go, p1_go, p0_dp;
  logic [NGRP-1:0] avail1;
  logic            dp_ok1;

  logic [LW-1:0]   start0_q, start1_q;
  logic            found0, found1;
  logic [LW-1:0]   idx0, idx1;
  logic [NGRP-1:0] gnt0, gnt1;

  wdi_sched_slot #(.NL(NL), .LW(LW)) u_slot0 (
    .rdy_loc (rdy_even),
    .cls_loc (cls_even),
    .avail   (grp_free),
    .dp_ok   (1'b1),
    .start   (start0_q),
    .found   (found0),
    .idx     (idx0),
    .gnt     (gnt0)
  );

  assign p0_go  = found0 && !rst;
  assign p0_dp  = p0_go && (gnt0 == DP_MASK);
  assign avail1 = p0_dp ? '0 : (p0_go ? (grp_free & ~gnt0) : grp_free);
  assign dp_ok1 = !p0_go;

  wdi_sched_slot #(.NL(NL), .LW(LW)) u_slot1 (
    .rdy_loc (rdy_odd),
    .cls_loc (cls_odd),
    .avail   (avail1),
    .dp_ok   (dp_ok1),
    .start   (start1_q),
    .found   (found1),
    .idx     (idx1),
    .gnt     (gnt1)
  );

  assign p1_go = found1 && !rst;

  assign iss_vld    = {p1_go, p0_go};
  assign iss_wid0   = {idx0, 1'b0};
  assign iss_wid1   = {idx1, 1'b1};
  assign iss_grant0 = p0_go ? gnt0 : '0;
  assign iss_grant1 = p1_go ? gnt1 : '0;
  assign grp_take   = iss_grant0 | iss_grant1;

  wdi_group_track #(.CORE_HOLD(CORE_HOLD), .SFU_HOLD(SFU_HOLD)) u_track (
    .clk      (clk),
    .rst      (rst),
    .take     (grp_take),
    .grp_free (grp_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start0_q <= '0;
      start1_q <= '0;
    end else begin
      if (p0_go) start0_q <= idx0 + 1'b1;
      if (p1_go) start1_q <= idx1 + 1'b1;
    end
  end
endmodule

// File: rtl/warp_dual_issue_chk.sv
module warp_dual_issue_chk #(
  parameter int NUM_WARPS = 8,
  parameter int SFU_HOLD = 8,
  parameter int WID_W = $clog2(NUM_WARPS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_WARPS-1:0]   warp_rdy,
  input logic [3*NUM_WARPS-1:0] warp_cls,
  input logic [1:0]             iss_vld,
  input logic [WID_W-1:0]       iss_wid0,
  input logic [WID_W-1:0]       iss_wid1,
  input logic [3:0]             iss_grant0,
  input logic [3:0]             iss_grant1,
  input logic [3:0]             grp_free
);
  localparam int AW = $clog2(SFU_HOLD + 1);
  logic [3:0]    took;
  logic [AW-1:0] sfu_age_q;

  assign took = (iss_vld[0] ? iss_grant0 : 4'b0) | (iss_vld[1] ? iss_grant1 : 4'b0);

  always_ff @(posedge clk) begin
    if (rst) sfu_age_q <= AW'(SFU_HOLD);
    else if (took[3]) sfu_age_q <= AW'(1);
    else if (int'(sfu_age_q) < SFU_HOLD) sfu_age_q <= sfu_age_q + 1'b1;
  end

  p_even_ready_r1: assert property (@(posedge clk) disable iff (rst)
    iss_vld[0] |-> (!iss_wid0[0] && warp_rdy[iss_wid0]));
  p_odd_ready_r1: assert property (@(posedge clk) disable iff (rst)
    iss_vld[1] |-> (iss_wid1[0] && warp_rdy[iss_wid1]));
  p_disjoint_r3: assert property (@(posedge clk) disable iff (rst)
    (iss_vld == 2'b11) |-> ((iss_grant0 & iss_grant1) == 4'b0));
  p_dp_alone0_r4: assert property (@(posedge clk) disable iff (rst)
    (iss_vld[0] && iss_grant0 == 4'b0011) |-> !iss_vld[1]);
  p_dp_alone1_r4: assert property (@(posedge clk) disable iff (rst)
    (iss_vld[1] && iss_grant1 == 4'b0011) |-> !iss_vld[0]);
  p_free_only_r5: assert property (@(posedge clk) disable iff (rst)
    (took & ~grp_free) == 4'b0);
  p_col_a_hold_r5: assert property (@(posedge clk) disable iff (rst)
    took[0] |=> !took[0]);
  p_col_b_hold_r5: assert property (@(posedge clk) disable iff (rst)
    took[1] |=> !took[1]);
  p_mem_hold_r5: assert property (@(posedge clk) disable iff (rst)
    took[2] |=> !took[2]);
  p_sfu_hold_r6: assert property (@(posedge clk) disable iff (rst)
    took[3] |-> (int'(sfu_age_q) >= SFU_HOLD));
  p_bad_class0_r9: assert property (@(posedge clk) disable iff (rst)
    iss_vld[0] |-> (warp_cls[3*iss_wid0 +: 3] <= 3'd4));
  p_bad_class1_r9: assert property (@(posedge clk) disable iff (rst)
    iss_vld[1] |-> (warp_cls[3*iss_wid1 +: 3] <= 3'd4));

  always @(posedge clk) begin
    if (rst) p_quiet_reset_r10: assert (iss_vld == 2'b00);
  end
endmodule

bind warp_dual_issue warp_dual_issue_chk #(
  .NUM_WARPS (NUM_WARPS),
  .SFU_HOLD  (SFU_HOLD),
  .WID_W     (WID_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .warp_rdy   (warp_rdy),
  .warp_cls   (warp_cls),
  .iss_vld    (iss_vld),
  .iss_wid0   (iss_wid0),
  .iss_wid1   (iss_wid1),
  .iss_grant0 (iss_grant0),
  .iss_grant1 (iss_grant1),
  .grp_free   (grp_free)
);

// File: tb/tb_warp_dual_issue.sv
module tb_warp_dual_issue;
  localparam int NW = 8;
  localparam int NL = NW / 2;
  localparam int WW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]   rdy = '0;
  logic [3*NW-1:0] cls = '0;
  logic [1:0]      iss_vld;
  logic [WW-1:0]   iss_wid0, iss_wid1;
  logic [3:0]      iss_grant0, iss_grant1;

  always #5 clk = ~clk;

  warp_dual_issue #(.NUM_WARPS(NW)) dut (
    .clk(clk), .rst(rst), .warp_rdy(rdy), .warp_cls(cls),
    .iss_vld(iss_vld), .iss_wid0(iss_wid0), .iss_wid1(iss_wid1),
    .iss_grant0(iss_grant0), .iss_grant1(iss_grant1)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state: absolute cycle at which each group is free again
  int free_at[4];
  int last_loc[2];
  int cyc;
  bit [1:0] e_vld;
  int e_w[2];
  bit [3:0] e_g[2];
  bit [1:0] a_vld;
  int a_w[2];
  bit [3:0] a_g[2];

  function automatic bit [3:0] want(input int c, input bit [3:0] av, input bit dpok);
    if (c == 0 || c == 1) return av[0] ? 4'b0001 : (av[1] ? 4'b0010 : 4'b0000);
    if (c == 2) return (dpok && av[0] && av[1]) ? 4'b0011 : 4'b0000;
    if (c == 3) return av[2] ? 4'b0100 : 4'b0000;
    if (c == 4) return av[3] ? 4'b1000 : 4'b0000;
    return 4'b0000;
  endfunction

  task automatic model_reset();
    for (int g = 0; g < 4; g++) free_at[g] = 0;
    last_loc[0] = NL - 1;
    last_loc[1] = NL - 1;
    cyc = 0;
  endtask

  task automatic model_eval();
    bit [3:0] fr;
    for (int g = 0; g < 4; g++) fr[g] = (cyc >= free_at[g]);
    e_vld = 2'b00;
    for (int p = 0; p < 2; p++) begin
      bit [3:0] av;
      bit dpok;
      e_g[p] = 4'b0;
      e_w[p] = 0;
      if (p == 0) begin
        av = fr;
        dpok = 1'b1;
      end else begin
        av = e_vld[0] ? ((e_g[0] == 4'b0011) ? 4'b0000 : (fr & ~e_g[0])) : fr;
        dpok = !e_vld[0];
      end
      for (int k = 1; k <= NL; k++) begin
        int loc;
        int w;
        bit [3:0] g;
        loc = (last_loc[p] + k) % NL;
        w = 2 * loc + p;
        if (!e_vld[p] && rdy[w]) begin
          g = want(int'(cls[3*w +: 3]), av, dpok);
          if (g != 4'b0) begin
            e_vld[p] = 1'b1;
            e_w[p] = w;
            e_g[p] = g;
          end
        end
      end
    end
  endtask

  task automatic model_commit();
    for (int p = 0; p < 2; p++) begin
      if (e_vld[p]) begin
        last_loc[p] = e_w[p] / 2;
        for (int g = 0; g < 4; g++)
          if (e_g[p][g]) free_at[g] = cyc + ((g == 3) ? 8 : 2);
      end
    end
    cyc++;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // at a negedge with inputs driven: sample, compare with model, advance one edge
  task automatic step(input bit cmp, input string tag);
    #1;
    a_vld = iss_vld;
    a_w[0] = int'(iss_wid0);
    a_w[1] = int'(iss_wid1);
    a_g[0] = iss_grant0;
    a_g[1] = iss_grant1;
    model_eval();
    if (cmp) begin
      for (int p = 0; p < 2; p++) begin
        int act;
        int exp;
        act = {a_vld[p], (a_vld[p] ? a_w[p][WW-1:0] : 3'd0), a_g[p]};
        exp = {e_vld[p], (e_vld[p] ? e_w[p][WW-1:0] : 3'd0), (e_vld[p] ? e_g[p] : 4'b0)};
        check(act == exp, tag, act, exp);
      end
      check(!(a_vld == 2'b11 && (a_g[0] & a_g[1]) != 4'b0),
            "R3 overlapping grants", int'(a_g[0] & a_g[1]), 0);
    end
    @(posedge clk);
    model_commit();
    @(negedge clk);
  endtask

  task automatic expect_port(input int p, input bit v, input int w, input bit [3:0] g,
                             input string tag);
    int act;
    int exp;
    act = {a_vld[p], (a_vld[p] ? a_w[p][WW-1:0] : 3'd0), a_g[p]};
    exp = {v, (v ? w[WW-1:0] : 3'd0), (v ? g : 4'b0)};
    check(act == exp, tag, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill(input bit [NW-1:0] r, input int c);
    rdy = r;
    for (int w = 0; w < NW; w++) cls[3*w +: 3] = 3'(c);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf;
    model_reset();
    // R10: reset held with ready warps -> nothing valid
    fill('1, 0);
    @(negedge clk);
    #1;
    check(iss_vld == 2'b00, "R10 valid during reset", int'(iss_vld), 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(iss_vld == 2'b00, "R10 valid during reset", int'(iss_vld), 0);

    // R2 R7 R5: all integer, both columns then a one-cycle gap
    do_reset();
    fill('1, 0);
    step(1, "R2 int pair");
    expect_port(0, 1, 0, 4'b0001, "R2 port0 first int to column A");
    expect_port(1, 1, 1, 4'b0010, "R2 port1 int to column B");
    step(1, "R5 columns held");
    expect_port(0, 0, 0, 0, "R5 column busy second cycle port0");
    expect_port(1, 0, 0, 0, "R5 column busy second cycle port1");
    step(1, "R7 next warps");
    expect_port(0, 1, 2, 4'b0001, "R7 port0 advances to warp 2");
    expect_port(1, 1, 3, 4'b0010, "R7 port1 advances to warp 3");
    for (int i = 0; i < 6; i++) step(1, "R7 rotation");

    // R4: double float issues alone
    do_reset();
    fill('1, 0);
    cls[2:0] = 3'd2;
    step(1, "R4 dp");
    expect_port(0, 1, 0, 4'b0011, "R4 dp takes both columns");
    expect_port(1, 0, 0, 0, "R4 no partner with dp");
    step(1, "R4 after dp");
    expect_port(0, 0, 0, 0, "R4 columns still held after dp");

    // R6: special-function held 8 cycles, only sfu work pending
    do_reset();
    fill('1, 4);
    step(1, "R6 sfu");
    expect_port(0, 1, 0, 4'b1000, "R6 first sfu grant");
    expect_port(1, 0, 0, 0, "R8 port1 loses sfu to port0");
    for (int i = 1; i < 8; i++) begin
      step(1, "R6 sfu busy");
      expect_port(0, 0, 0, 0, "R6 sfu busy port0");
      expect_port(1, 0, 0, 0, "R6 sfu busy port1");
    end
    step(1, "R6 sfu free again");
    expect_port(0, 1, 2, 4'b1000, "R6 sfu free after 8 cycles");

    // R6: other groups keep issuing while sfu busy
    do_reset();
    fill('1, 0);
    cls[2:0] = 3'd4;
    cls[5:3] = 3'd3;
    step(1, "R6 mix");
    expect_port(0, 1, 0, 4'b1000, "R6 sfu on port0");
    expect_port(1, 1, 1, 4'b0100, "R6 load/store on port1");
    step(1, "R6 mix");
    expect_port(0, 1, 2, 4'b0001, "R6 column A issues under busy sfu");
    expect_port(1, 1, 3, 4'b0010, "R6 column B issues under busy sfu");

    // R8: conflict on load/store, port1 falls back to its integer warp
    do_reset();
    fill(8'b0000_1011, 7);
    cls[2:0] = 3'd3;
    cls[5:3] = 3'd3;
    cls[11:9] = 3'd0;
    step(1, "R8 conflict");
    expect_port(0, 1, 0, 4'b0100, "R8 port0 wins load/store");
    expect_port(1, 1, 3, 4'b0001, "R8 port1 retries with warp 3");

    // R9: illegal classes never issue
    do_reset();
    for (int c = 5; c < 8; c++) begin
      fill('1, c);
      step(1, "R9 illegal class");
      expect_port(0, 0, 0, 0, "R9 illegal class port0");
      expect_port(1, 0, 0, 0, "R9 illegal class port1");
    end

    // R1 R3 R5 R7 R8: pseudo-random sweep against the model
    do_reset();
    lf = 32'hACE1_2468;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rdy = lf[NW-1:0] | lf[15:8];
      for (int w = 0; w < NW; w++) begin
        int c;
        c = int'(lf[(w*3+i) % 29 +: 3]);
        cls[3*w +: 3] = 3'((c == 7 && w[0]) ? 0 : c);
      end
      step(1, "R1 R5 R7 R8 model sweep");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule